// File: doc/BRIEF.md
# Reload-Counter PWM Timer Channel

This block is one pulse-width-modulation timer channel. A counter of `CNT_W` bits starts from a programmable reload value, increments once per clock and, after it reaches the all-ones terminal count, restarts from the reload value. Two compare values, a window start and a window end, mark the part of each period in which the output is asserted. Software writes four registers through a single-cycle write port: a control word, the reload value, the window start and the window end.

To get a period of P+1 clocks, software writes all-ones minus P as the reload value. To get D asserted clocks at the start of each period, it writes the reload value as the window start and the reload value plus D as the window end. The reload value and both compare values are staged. They move into the active copies only at a reload event, so a period that has already begun never changes shape. An inversion bit acts after the comparator and sets the output polarity.

A two-state controller drives the channel. In state `ST_IDLE` the counter follows the staged reload value and the output sits at its inactive level. The transition START (`ST_IDLE` to `ST_RUN`) happens when all five run fields of the control word are set. In `ST_RUN` the transition COUNT increments the counter, and the transition WRAP (`ST_RUN` to `ST_RUN`) reloads the counter and the active compare values at the terminal count. The transition HALT (`ST_RUN` to `ST_IDLE`) happens as soon as any run field is clear.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset `count` is 0, `running` is 0, `pwm_out` is 0, and every register and active copy holds 0.
- R2: A write with `wr_en` high stores `wr_data` into the register selected by `wr_addr`: 0 selects the control word, 1 the reload value, 2 the window start and 3 the window end. The register takes the new value at the clock edge that samples the write.
- R3: The control word uses these bits: bit 0 timer enable, bit 1 auto-reload enable, bit 2 full-width mode, bit 3 tick source select, bit 4 PWM mode, bit 5 output invert. The channel enters `ST_RUN` (`running` = 1) one clock after the control register holds bits 0 to 4 all set. Any other combination leaves it idle.
- R4: While `running` is 0, `count` equals the staged reload value and `pwm_out` equals the invert bit (the inactive level).
- R5: While running, `count` rises by one each clock. After the all-ones value it takes the staged reload value, so the period is 2^CNT_W minus the reload value.
- R6: While running, the un-inverted output is 1 exactly when window start <= `count` < window end, using the active copies.
- R7: If the active window end is less than or equal to the active window start, the output stays at the inactive level for the whole period.
- R8: Reload, window start and window end values written during a period take effect only at the next WRAP or START. The period in progress keeps its old values.
- R9: The invert bit flips `pwm_out` with no delay from the control register, both while running and while idle.
- R10: Writing a control word with any of bits 0 to 4 clear stops the channel. One clock after the register changes, `running` is 0 and the counter returns to the staged reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM output after polarity inversion |
| running | output | 1 | High while the channel is in `ST_RUN` |
| count | output | CNT_W | Current counter value |

## Verification
Two events can fall in the same cycle: a software write to a staged register and a WRAP that copies the staged values into the active set. The bench places writes on the cycle of the terminal count and on the cycles just before and after it. A behavioural model applies the write after the reload. The bench compares `count`, `pwm_out` and `running` on every clock, so a write that takes effect a period too early or too late shows up as a mismatch in the output window. A stop written on the terminal-count cycle covers the collision of HALT with WRAP in the same way.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    typedef enum logic [1:0] {
        A_CTRL   = 2'd0,
        A_RELOAD = 2'd1,
        A_WSTART = 2'd2,
        A_WEND   = 2'd3
    } reg_addr_e;

    localparam int CTRL_W = 6;

    typedef struct packed {
        logic invert;     // bit 5
        logic pwm_mode;   // bit 4
        logic tick_sel;   // bit 3
        logic wide;       // bit 2
        logic auto_rel;   // bit 1
        logic enable;     // bit 0
    } ctrl_t;

    function automatic logic run_fields_ok(input ctrl_t c);
        return c.enable & c.auto_rel & c.wide & c.tick_sel & c.pwm_mode;
    endfunction

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] rel_stg,
    output logic [CNT_W-1:0] ws_stg,
    output logic [CNT_W-1:0] we_stg
);
    localparam int NREG = 4;

    logic [NREG-1:0] sel;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_dec
            assign sel[g] = wr_en && (wr_addr == 2'(g));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            rel_stg <= '0;
            ws_stg  <= '0;
            we_stg  <= '0;
        end else begin
            if (sel[A_CTRL])   ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (sel[A_RELOAD]) rel_stg <= wr_data;
            if (sel[A_WSTART]) ws_stg  <= wr_data;
            if (sel[A_WEND])   we_stg  <= wr_data;
        end
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));  // R2

endmodule

// File: rtl/pwm_tmr_seq.sv
module pwm_tmr_seq
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_ok,
    input  logic [CNT_W-1:0] rel_stg,
    input  logic [CNT_W-1:0] ws_stg,
    input  logic [CNT_W-1:0] we_stg,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ws_act,
    output logic [CNT_W-1:0] we_act,
    output logic             running
);
    localparam logic [CNT_W-1:0] TERM = '1;

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] ws_q, we_q;
    logic             load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = rel_stg;
                load  = 1'b1;
                if (run_ok) state_d = ST_RUN;          // START
            end
            ST_RUN: begin
                if (!run_ok) begin                      // HALT
                    state_d = ST_IDLE;
                    cnt_d   = rel_stg;
                    load    = 1'b1;
                end else if (cnt_q == TERM) begin       // WRAP
                    cnt_d = rel_stg;
                    load  = 1'b1;
                end else begin                          // COUNT
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ws_q  <= '0;
            we_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (load) begin
                ws_q <= ws_stg;
                we_q <= we_stg;
            end
        end
    end

    assign cnt     = cnt_q;
    assign ws_act  = ws_q;
    assign we_act  = we_q;
    assign running = (state_q == ST_RUN);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_ok && cnt_q != TERM) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));  // R5

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_ok && cnt_q == TERM) |=> (cnt_q == $past(rel_stg)));  // R5

    AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!running) |=> (cnt_q == $past(rel_stg)));  // R4

    AST_MIDPERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_ok && cnt_q != TERM) |=> ($stable(ws_q) && $stable(we_q)));  // R8

endmodule

// File: rtl/pwm_tmr_cmp.sv
module pwm_tmr_cmp #(
    parameter int CNT_W = 32
) (
    input  logic             running,
    input  logic             invert,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ws_act,
    input  logic [CNT_W-1:0] we_act,
    output logic             pwm_out
);
    logic past_start, before_end, in_window;

    always_comb begin
        past_start = (cnt >= ws_act);
        before_end = (cnt < we_act);
        in_window  = running && past_start && before_end;
        pwm_out    = in_window ^ invert;
    end

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             running,
    output logic [CNT_W-1:0] count
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] rel_stg, ws_stg, we_stg;
    logic [CNT_W-1:0] ws_act, we_act;
    logic             run_ok;

    pwm_tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .rel_stg (rel_stg),
        .ws_stg  (ws_stg),
        .we_stg  (we_stg)
    );

    assign run_ok = run_fields_ok(ctrl);

    pwm_tmr_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_ok  (run_ok),
        .rel_stg (rel_stg),
        .ws_stg  (ws_stg),
        .we_stg  (we_stg),
        .cnt     (count),
        .ws_act  (ws_act),
        .we_act  (we_act),
        .running (running)
    );

    pwm_tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
        .running (running),
        .invert  (ctrl.invert),
        .cnt     (count),
        .ws_act  (ws_act),
        .we_act  (we_act),
        .pwm_out (pwm_out)
    );

    AST_START_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(run_ok));  // R3

    AST_STOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !run_ok) |=> !running);  // R10

    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running) |-> (pwm_out == ctrl.invert));  // R4

    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (we_act <= ws_act) |-> (pwm_out == ctrl.invert));  // R7

endmodule

// File: tb/test_pwm_reload_timer.sv
module test_pwm_reload_timer;
    localparam int W = 32;
    localparam logic [W-1:0] TERM = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_out, running;
    logic [W-1:0] count;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    pwm_reload_timer #(.CNT_W(W)) i_pwm_reload_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .running(running), .count(count)
    );

    // behavioural reference model
    logic [5:0]   m_ctrl = '0;
    logic [W-1:0] m_rel = '0, m_ws = '0, m_we = '0;
    logic [W-1:0] m_ws_a = '0, m_we_a = '0, m_cnt = '0;
    bit           m_run = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0; m_rel = '0; m_ws = '0; m_we = '0;
            m_ws_a = '0; m_we_a = '0; m_cnt = '0; m_run = 0;
        end else begin
            bit ok;
            ok = (m_ctrl[4:0] == 5'h1F);
            if (!m_run || !ok || m_cnt == TERM) begin
                m_cnt = m_rel; m_ws_a = m_ws; m_we_a = m_we;
                m_run = m_run ? ok : ok;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_ctrl = wr_data[5:0];
                    2'd1: m_rel  = wr_data;
                    2'd2: m_ws   = wr_data;
                    default: m_we = wr_data;
                endcase
            end
        end
    end

    function automatic bit model_out();
        return (m_run && m_cnt >= m_ws_a && m_cnt < m_we_a) ^ m_ctrl[5];
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(cur_req, count, m_cnt, "count");
            check(cur_req, {31'd0, running}, {31'd0, m_run}, "running");
            check(cur_req, {31'd0, pwm_out}, {31'd0, model_out()}, "pwm_out");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_count(input logic [W-1:0] v);
        int guard = 0;
        while (count !== v && guard < 200) begin @(negedge clk); guard++; end
    endtask

    initial begin : watchdog
        #100000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", count, '0, "reset count");
        check("R1", {31'd0, running}, '0, "reset running");
        check("R1", {31'd0, pwm_out}, '0, "reset pwm_out");
        rst_n = 1'b1;
        idle(2);

        // R2 R4: program a 16-tick period, 4-tick duty, stay idle
        cur_req = "R2";
        wr(2'd1, 32'hFFFF_FFF0);
        wr(2'd2, 32'hFFFF_FFF0);
        wr(2'd3, 32'hFFFF_FFF4);
        cur_req = "R4";
        idle(4);

        // R3: one run field missing keeps it idle
        cur_req = "R3";
        wr(2'd0, 32'h0F);
        idle(4);
        wr(2'd0, 32'h17);
        idle(4);
        wr(2'd0, 32'h1F);
        // R5 R6: free running
        cur_req = "R5";
        idle(20);
        cur_req = "R6";
        idle(20);

        // R8: writes mid-period and on the terminal-count cycle
        cur_req = "R8";
        wait_count(32'hFFFF_FFF6);
        wr(2'd3, 32'hFFFF_FFF9);
        wait_count(32'hFFFF_FFFE);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'hFFFF_FFE8;  // lands on TERM cycle
        @(negedge clk);
        wr_en = 1'b0;
        idle(40);
        wr(2'd2, 32'hFFFF_FFEB);
        cur_req = "R6";
        idle(60);

        // R9: inversion while running
        cur_req = "R9";
        wr(2'd0, 32'h3F);
        idle(50);

        // R7: empty window
        cur_req = "R7";
        wr(2'd3, 32'hFFFF_FFEB);
        idle(60);
        wr(2'd3, 32'hFFFF_FFE0);
        idle(30);

        // R10: stop on the terminal-count cycle, then idle with inversion
        cur_req = "R10";
        wr(2'd3, 32'hFFFF_FFF0);
        wait_count(32'hFFFF_FFFE);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h2E;
        @(negedge clk);
        wr_en = 1'b0;
        idle(3);
        check("R10", {31'd0, running}, '0, "stopped running");
        check("R10", {31'd0, pwm_out}, 32'd1, "stopped inverted level");
        cur_req = "R4";
        wr(2'd1, 32'h0000_1234);
        idle(3);
        check("R4", count, 32'h0000_1234, "idle count follows reload");
        cur_req = "R9";
        wr(2'd0, 32'h00);
        idle(2);
        check("R9", {31'd0, pwm_out}, '0, "idle non-inverted level");
        cur_req = "R10";
        wr(2'd0, 32'h1F);
        idle(10);
        wr(2'd0, 32'h00);
        idle(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule